// File: doc/BRIEF.md
# Write-Protect Command Sequencer

This block sits between the captured write cycles of a sector-programmed non-volatile array and the logic that commits a loaded sector. Each captured write arrives as an address, a data byte and a one-cycle load strobe. The block keeps a protection flag. It watches the writes of each load window for two command sequences: a three-write unlock (which also turns protection on) and a six-write disable. When the page-load logic reports that the window has closed, the block decides whether the program cycle that follows may change the array.

A window always starts a program cycle, so the busy period runs whether or not the data is committed. When protection is on, the window must begin with the exact unlock prefix; otherwise the cycle runs with permission withheld and the array keeps its contents. The protection flag models a non-volatile bit. The ordinary reset does not clear it. Only a separate initial-state input, standing for the as-manufactured condition, and the disable command clear it. The page-load logic detects the gap timeout between writes and closes the window; this block only sees the close.

Top module: `wp_cmd_sequencer`

## Requirements
- R1: With `nv_init_n` and `rst_n` asserted low and then released, `prot_on`, `cyc_busy` and `cyc_permit` are all 0.
- R2: While `prot_on` is 0, every window close starts a cycle with `cyc_permit` = 1, whatever the writes were.
- R3: While `prot_on` is 0, a window whose first three writes are (address 0x5555, data 0xAA), (0x2AAA, 0x55), (0x5555, 0xA0) sets `prot_on` to 1, visible the cycle after the third write. Its cycle is permitted.
- R4: While `prot_on` is 1, a window whose first three writes are that same unlock sequence gives `cyc_permit` = 1, and `prot_on` stays 1.
- R5: While `prot_on` is 1, a window that does not open with the unlock prefix still raises `cyc_busy`, but with `cyc_permit` = 0.
- R6: A write that does not match the expected step sends the matcher back to its first step, and no sequence completes later in that window. A correct sequence that follows a stray write is therefore rejected.
- R7: A window whose first six writes are (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x80), (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, 0x20) clears `prot_on`, visible the cycle after the sixth write. Its cycle is permitted.
- R8: Pulsing `rst_n` alone leaves `prot_on` unchanged.
- R9: `cyc_busy` and `cyc_permit` are set at the window close and held stable until `cyc_done`. Both read 0 the cycle after `cyc_done`.
- R10: Writes and window closes that arrive while `cyc_busy` is 1 are ignored: `prot_on` and `cyc_permit` keep their values.
- R11: While `prot_on` is 1, a window that stops after the first five writes of the disable sequence is rejected, and `prot_on` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the matcher and cycle state (power cycle) |
| nv_init_n | input | 1 | Active-low initial state of the persistent protection flag |
| wr_stb | input | 1 | One-cycle strobe for a captured write |
| wr_addr | input | 16 | Captured write address |
| wr_data | input | 8 | Captured write data |
| win_close | input | 1 | Pulse: the load window has ended and the program cycle starts |
| cyc_done | input | 1 | Pulse: the program cycle timer has finished |
| cyc_busy | output | 1 | A program cycle is running |
| cyc_permit | output | 1 | The running cycle may change the array |
| prot_on | output | 1 | Protection flag |

## Verification
The hardest states to reach are the ones where a valid sequence sits in the wrong place. One case is an unlock that follows a stray write in the same window. Another is a disable that stops one write short. A third is a complete command sent while a cycle is still busy. The directed tests build each of these case by case from the write strobe and the close pulse. After every close they read `cyc_permit` and `prot_on`. They also pulse `rst_n` alone while protection is on, to show that the flag survives.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;
    localparam int TOK_N     = 5;
    localparam int TK_KEY1   = 0;
    localparam int TK_KEY2   = 1;
    localparam int TK_UNLOCK = 2;
    localparam int TK_DISPRE = 3;
    localparam int TK_DISFIN = 4;

    typedef enum logic [2:0] {
        ST_W1, ST_W2, ST_W3, ST_W4, ST_W5, ST_W6, ST_DONE
    } step_e;

    typedef struct packed {
        step_e step;
        logic  clean;
        logic  grant;
    } match_t;

    typedef struct packed {
        logic busy;
        logic permit;
    } cyc_t;
endpackage

// File: rtl/wp_tok_decode.sv
module wp_tok_decode
    import wp_seq_pkg::*;
#(
    parameter int             AW       = 16,
    parameter int             DW       = 8,
    parameter logic [AW-1:0]  ADDR_P   = 16'h5555,
    parameter logic [AW-1:0]  ADDR_Q   = 16'h2AAA,
    parameter logic [DW-1:0]  D_KEY1   = 8'hAA,
    parameter logic [DW-1:0]  D_KEY2   = 8'h55,
    parameter logic [DW-1:0]  D_UNLOCK = 8'hA0,
    parameter logic [DW-1:0]  D_DISPRE = 8'h80,
    parameter logic [DW-1:0]  D_DISFIN = 8'h20
) (
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [TOK_N-1:0] tok_hit
);
    function automatic logic [AW-1:0] tok_addr(input int idx);
        return (idx == TK_KEY2) ? ADDR_Q : ADDR_P;
    endfunction

    function automatic logic [DW-1:0] tok_data(input int idx);
        case (idx)
            TK_KEY1:   return D_KEY1;
            TK_KEY2:   return D_KEY2;
            TK_UNLOCK: return D_UNLOCK;
            TK_DISPRE: return D_DISPRE;
            default:   return D_DISFIN;
        endcase
    endfunction

    for (genvar g = 0; g < TOK_N; g++) begin : g_tok
        assign tok_hit[g] = (wr_addr == tok_addr(g)) && (wr_data == tok_data(g));
    end
endmodule

// File: rtl/wp_step_match.sv
module wp_step_match
    import wp_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [TOK_N-1:0] tok_hit,
    input  logic             win_close,
    input  logic             busy,
    output logic             en_hit,
    output logic             dis_hit,
    output logic             grant_now
);
    match_t m_q, m_d;
    logic   miss;

    always_comb begin
        m_d     = m_q;
        en_hit  = 1'b0;
        dis_hit = 1'b0;
        miss    = 1'b0;
        if (wr_stb && !busy) begin
            if (!m_q.clean) begin
                m_d.step = ST_W1;
            end else begin
                unique case (m_q.step)
                    ST_W1: if (tok_hit[TK_KEY1]) m_d.step = ST_W2; else miss = 1'b1;
                    ST_W2: if (tok_hit[TK_KEY2]) m_d.step = ST_W3; else miss = 1'b1;
                    ST_W3: begin
                        if (tok_hit[TK_UNLOCK]) begin
                            en_hit   = 1'b1;
                            m_d.step = ST_DONE;
                        end else if (tok_hit[TK_DISPRE]) begin
                            m_d.step = ST_W4;
                        end else begin
                            miss = 1'b1;
                        end
                    end
                    ST_W4: if (tok_hit[TK_KEY1]) m_d.step = ST_W5; else miss = 1'b1;
                    ST_W5: if (tok_hit[TK_KEY2]) m_d.step = ST_W6; else miss = 1'b1;
                    ST_W6: begin
                        if (tok_hit[TK_DISFIN]) begin
                            dis_hit  = 1'b1;
                            m_d.step = ST_DONE;
                        end else begin
                            miss = 1'b1;
                        end
                    end
                    default: m_d.step = ST_DONE;
                endcase
            end
            if (miss) begin
                m_d.step  = ST_W1;
                m_d.clean = 1'b0;
            end
        end
        if (en_hit || dis_hit) m_d.grant = 1'b1;
        grant_now = m_q.grant | en_hit | dis_hit;
        if (win_close && !busy) begin
            m_d.step  = ST_W1;
            m_d.clean = 1'b1;
            m_d.grant = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{step: ST_W1, clean: 1'b1, grant: 1'b0};
        else        m_q <= m_d;
    end

    a_r10_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(m_q))
        else $error("matcher state moved during a busy cycle");

    a_r6_miss_never_grants: assert property (@(posedge clk) disable iff (!rst_n)
        !m_q.clean |-> !grant_now)
        else $error("grant after a broken sequence");
endmodule

// File: rtl/wp_prot_store.sv
module wp_prot_store (
    input  logic clk,
    input  logic nv_init_n,
    input  logic en_hit,
    input  logic dis_hit,
    output logic prot_q
);
    logic prot_d;

    always_comb begin
        prot_d = prot_q;
        if (en_hit)  prot_d = 1'b1;
        if (dis_hit) prot_d = 1'b0;
    end

    always_ff @(posedge clk or negedge nv_init_n) begin
        if (!nv_init_n) prot_q <= 1'b0;
        else            prot_q <= prot_d;
    end

    a_r3_set_only_by_enable: assert property (@(posedge clk) disable iff (!nv_init_n)
        (!prot_q && !en_hit) |=> !prot_q)
        else $error("protection set without enable sequence");

    a_r7_clear_only_by_disable: assert property (@(posedge clk) disable iff (!nv_init_n)
        (prot_q && !dis_hit) |=> prot_q)
        else $error("protection cleared without disable sequence");
endmodule

// File: rtl/wp_cycle_ctl.sv
module wp_cycle_ctl
    import wp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_close,
    input  logic cyc_done,
    input  logic grant_now,
    input  logic prot_now,
    output logic busy,
    output logic permit
);
    cyc_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (!c_q.busy) begin
            if (win_close) begin
                c_d.busy   = 1'b1;
                c_d.permit = grant_now | !prot_now;
            end
        end else if (cyc_done) begin
            c_d.busy   = 1'b0;
            c_d.permit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy   = c_q.busy;
    assign permit = c_q.permit;

    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.busy && !cyc_done) |=> (c_q.busy && $stable(c_q.permit)))
        else $error("cycle state moved before cycle end");

    a_r9_no_permit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.busy |-> !c_q.permit)
        else $error("permit outside a cycle");
endmodule

// File: rtl/wp_cmd_sequencer.sv
module wp_cmd_sequencer
    import wp_seq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nv_init_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          win_close,
    input  logic          cyc_done,
    output logic          cyc_busy,
    output logic          cyc_permit,
    output logic          prot_on
);
    logic [TOK_N-1:0] tok_hit;
    logic             en_hit;
    logic             dis_hit;
    logic             grant_now;

    wp_tok_decode #(.AW(AW), .DW(DW)) u_dec (
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tok_hit (tok_hit)
    );

    wp_step_match u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .tok_hit   (tok_hit),
        .win_close (win_close),
        .busy      (cyc_busy),
        .en_hit    (en_hit),
        .dis_hit   (dis_hit),
        .grant_now (grant_now)
    );

    wp_prot_store u_prot (
        .clk       (clk),
        .nv_init_n (nv_init_n),
        .en_hit    (en_hit),
        .dis_hit   (dis_hit),
        .prot_q    (prot_on)
    );

    wp_cycle_ctl u_cyc (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_close (win_close),
        .cyc_done  (cyc_done),
        .grant_now (grant_now),
        .prot_now  (prot_on),
        .busy      (cyc_busy),
        .permit    (cyc_permit)
    );
endmodule

// File: tb/test_wp_cmd_sequencer.sv
module test_wp_cmd_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nv_init_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        win_close = 1'b0;
    logic        cyc_done = 1'b0;
    logic        cyc_busy, cyc_permit, prot_on;
    int          checks = 0;
    int          errors = 0;

    always #10 clk = ~clk;

    wp_cmd_sequencer i_wp_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .nv_init_n(nv_init_n),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .win_close(win_close), .cyc_done(cyc_done),
        .cyc_busy(cyc_busy), .cyc_permit(cyc_permit), .prot_on(prot_on)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic unlock_seq();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
    endtask

    task automatic data_bytes(input int n);
        for (int i = 0; i < n; i++) wr(16'h0100 + 16'(i), 8'(i * 7 + 3));
    endtask

    task automatic run_cycle(input bit exp_permit, input string req);
        @(negedge clk); win_close = 1'b1;
        @(negedge clk); win_close = 1'b0;
        chk(cyc_busy == 1'b1, req, cyc_busy, 1);
        chk(cyc_permit == exp_permit, req, cyc_permit, exp_permit);
        repeat (3) @(negedge clk);
        chk(cyc_busy == 1'b1 && cyc_permit == exp_permit, "R9", cyc_permit, exp_permit);
        cyc_done = 1'b1;
        @(negedge clk); cyc_done = 1'b0;
        chk(cyc_busy == 1'b0 && cyc_permit == 1'b0, "R9", {cyc_busy, cyc_permit}, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        nv_init_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk(prot_on == 1'b0, "R1", prot_on, 0);
        chk(cyc_busy == 1'b0 && cyc_permit == 1'b0, "R1", {cyc_busy, cyc_permit}, 0);
    endtask

    task automatic t_open_data();
        data_bytes(4);
        run_cycle(1'b1, "R2");
    endtask

    task automatic t_busy_ignore();
        @(negedge clk); win_close = 1'b1;
        @(negedge clk); win_close = 1'b0;
        unlock_seq();
        chk(prot_on == 1'b0, "R10", prot_on, 0);
        @(negedge clk); win_close = 1'b1;
        @(negedge clk); win_close = 1'b0;
        chk(cyc_permit == 1'b1 && cyc_busy == 1'b1, "R10", cyc_permit, 1);
        cyc_done = 1'b1;
        @(negedge clk); cyc_done = 1'b0;
        chk(cyc_busy == 1'b0, "R10", cyc_busy, 0);
    endtask

    task automatic t_enable();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
        chk(prot_on == 1'b0, "R3", prot_on, 0);
        wr(16'h5555, 8'hA0);
        chk(prot_on == 1'b1, "R3", prot_on, 1);
        data_bytes(3);
        run_cycle(1'b1, "R3");
    endtask

    task automatic t_power_cycle();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(prot_on == 1'b1, "R8", prot_on, 1);
    endtask

    task automatic t_plain_protected();
        data_bytes(5);
        run_cycle(1'b0, "R5");
    endtask

    task automatic t_broken_prefix();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h0042, 8'h11);
        unlock_seq();
        run_cycle(1'b0, "R6");
    endtask

    task automatic t_late_prefix();
        data_bytes(1);
        unlock_seq();
        run_cycle(1'b0, "R6");
        chk(prot_on == 1'b1, "R6", prot_on, 1);
    endtask

    task automatic t_unlock();
        unlock_seq();
        data_bytes(4);
        run_cycle(1'b1, "R4");
        chk(prot_on == 1'b1, "R4", prot_on, 1);
    endtask

    task automatic t_partial_disable();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
        run_cycle(1'b0, "R11");
        chk(prot_on == 1'b1, "R11", prot_on, 1);
    endtask

    task automatic t_disable();
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
        chk(prot_on == 1'b1, "R7", prot_on, 1);
        wr(16'h5555, 8'h20);
        chk(prot_on == 1'b0, "R7", prot_on, 0);
        run_cycle(1'b1, "R7");
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        t_reset();
        t_open_data();
        t_busy_ignore();
        t_enable();
        t_power_cycle();
        t_plain_protected();
        t_broken_prefix();
        t_late_prefix();
        t_unlock();
        t_partial_disable();
        t_disable();
        data_bytes(2);
        run_cycle(1'b1, "R2");
        summary();
    end
endmodule